// File: doc/BRIEF.md
# Receive Runt and Collision Statistics Counters

This block keeps two small event tallies that the receive path copies into each status word it writes for a good frame. One tally counts network collisions seen while this node is not sending. The other counts short, aborted frames (runts) that were aimed at this node. A runt is only counted when enough of its destination address arrived for the address filter to reach a verdict, and that filter said the frame matched.

Each tally covers only the interval since the last good frame. The descriptor writer pulses a completion strobe in the cycle it stores a good frame's status. In that cycle the two outputs hold the values for that status entry. On the following clock edge both tallies restart. An event that arrives in the same cycle as the strobe is counted toward the new interval. Both tallies stop at their all-ones value and never wrap.

Top module: `rxstat_counters`

## Requirements
- R1: After reset, both `col_cnt_o` and `runt_cnt_o` read 0.
- R2: A cycle with `col_det_i` high and `tx_active_i` low raises `col_cnt_o` by one on the next clock edge.
- R3: A collision flagged while `tx_active_i` is high leaves `col_cnt_o` unchanged.
- R4: A cycle with `runt_end_i` high, `runt_match_i` high and `runt_bits_i` at least `MIN_RUNT_BITS` (default 48) raises `runt_cnt_o` by one on the next edge.
- R5: A runt whose `runt_bits_i` is below `MIN_RUNT_BITS` (for example 47) leaves `runt_cnt_o` unchanged.
- R6: A runt with `runt_match_i` low leaves `runt_cnt_o` unchanged, whatever its length.
- R7: Each count stops at 255 (all ones for `CNT_W` = 8) and does not wrap.
- R8: In the cycle `rx_done_i` is high, the outputs show the tallies accumulated so far. If no event arrives in that cycle, both read 0 after the next edge.
- R9: An event that qualifies in the same cycle as `rx_done_i` leaves the affected count at 1 after the edge.
- R10: The two counts are independent. A collision and a runt in the same cycle each advance only their own count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| col_det_i | input | 1 | Single-cycle pulse: a collision was detected on the medium |
| tx_active_i | input | 1 | Level: this node is transmitting |
| runt_end_i | input | 1 | Single-cycle pulse: a runt frame ended |
| runt_match_i | input | 1 | Qualifier with `runt_end_i`: the destination address matched |
| runt_bits_i | input | BITS_W | Qualifier with `runt_end_i`: number of valid destination-address bits received |
| rx_done_i | input | 1 | Single-cycle pulse: a good frame's status entry is being written |
| col_cnt_o | output | CNT_W | Collisions since the last good receive |
| runt_cnt_o | output | CNT_W | Countable runts since the last good receive |

## Verification
A corrupted tally, or an increment that is lost or doubled, shows on the count output one edge after the event. The bench compares every cycle, so such an error is caught within one cycle. A wrong qualification also shows one edge later: a collision counted while transmitting, or a runt of 47 bits or with no address match that is counted. An error in clearing only shows when a later status entry is written, so the bench reads the outputs both in the strobe cycle and in the cycle after it. Saturation faults need more than 255 events before they can show, so the bench drives past that limit on both tallies.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

  // Index of each tally within the counter array
  typedef enum int unsigned {
    TALLY_COL  = 0,
    TALLY_RUNT = 1
  } tally_e;

  localparam int unsigned NUM_TALLIES = 2;

endpackage

// File: rtl/rxstat_rst_sync.sv
module rxstat_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // Assert at once, release after STAGES edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/rxstat_event_qual.sv
module rxstat_event_qual #(
  parameter int unsigned BITS_W        = 10,
  parameter int unsigned MIN_RUNT_BITS = 48
) (
  input  logic              col_det_i,
  input  logic              tx_active_i,
  input  logic              runt_end_i,
  input  logic              runt_match_i,
  input  logic [BITS_W-1:0] runt_bits_i,
  output logic              col_inc_o,
  output logic              runt_inc_o
);

  localparam logic [BITS_W-1:0] MIN_BITS = BITS_W'(MIN_RUNT_BITS);

  logic runt_long_enough;

  always_comb begin
    // Collisions of our own transmissions are not network statistics
    col_inc_o        = col_det_i & ~tx_active_i;
    // The filter needs enough address bits before its verdict means anything
    runt_long_enough = (runt_bits_i >= MIN_BITS);
    runt_inc_o       = runt_end_i & runt_match_i & runt_long_enough;
  end

endmodule

// File: rtl/rxstat_sat_counter.sv
module rxstat_sat_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr_i) begin
      // New interval starts; a same-cycle event belongs to it
      cnt_en = 1'b1;
      cnt_d  = inc_i ? CNT_ONE : '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rxstat_counters.sv
module rxstat_counters
  import rxstat_pkg::*;
#(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned BITS_W        = 10,
  parameter int unsigned MIN_RUNT_BITS = 48,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              col_det_i,
  input  logic              tx_active_i,
  input  logic              runt_end_i,
  input  logic              runt_match_i,
  input  logic [BITS_W-1:0] runt_bits_i,
  input  logic              rx_done_i,
  output logic [CNT_W-1:0]  col_cnt_o,
  output logic [CNT_W-1:0]  runt_cnt_o
);

  logic                   rst_n_sync;
  logic                   col_inc;
  logic                   runt_inc;
  logic [NUM_TALLIES-1:0] inc_vec;
  logic [CNT_W-1:0]       cnt_vec [NUM_TALLIES];

  rxstat_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rst_n_sync_o (rst_n_sync)
  );

  rxstat_event_qual #(
    .BITS_W        (BITS_W),
    .MIN_RUNT_BITS (MIN_RUNT_BITS)
  ) u_qual (
    .col_det_i    (col_det_i),
    .tx_active_i  (tx_active_i),
    .runt_end_i   (runt_end_i),
    .runt_match_i (runt_match_i),
    .runt_bits_i  (runt_bits_i),
    .col_inc_o    (col_inc),
    .runt_inc_o   (runt_inc)
  );

  always_comb begin
    inc_vec             = '0;
    inc_vec[TALLY_COL]  = col_inc;
    inc_vec[TALLY_RUNT] = runt_inc;
  end

  for (genvar g = 0; g < NUM_TALLIES; g++) begin : g_tally
    rxstat_sat_counter #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_n_sync),
      .clr_i  (rx_done_i),
      .inc_i  (inc_vec[g]),
      .cnt_o  (cnt_vec[g])
    );
  end

  assign col_cnt_o  = cnt_vec[TALLY_COL];
  assign runt_cnt_o = cnt_vec[TALLY_RUNT];

endmodule

// File: rtl/rxstat_counters_chk.sv
module rxstat_counters_chk #(
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned BITS_W        = 10,
  parameter int unsigned MIN_RUNT_BITS = 48
) (
  input logic              clk_i,
  input logic              rst_n_sync,
  input logic              col_det_i,
  input logic              tx_active_i,
  input logic              runt_end_i,
  input logic              runt_match_i,
  input logic [BITS_W-1:0] runt_bits_i,
  input logic              rx_done_i,
  input logic [CNT_W-1:0]  col_cnt_o,
  input logic [CNT_W-1:0]  runt_cnt_o
);

  localparam logic [CNT_W-1:0]  MAXV = '1;
  localparam logic [BITS_W-1:0] MINB = BITS_W'(MIN_RUNT_BITS);

  logic col_ev;
  logic runt_ev;
  assign col_ev  = col_det_i && !tx_active_i;
  assign runt_ev = runt_end_i && runt_match_i && (runt_bits_i >= MINB);

  a_r2_col_step: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (col_ev && !rx_done_i && col_cnt_o != MAXV) |=> col_cnt_o == $past(col_cnt_o) + 1'b1);

  a_r3_tx_ignored: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (col_det_i && tx_active_i && !rx_done_i) |=> $stable(col_cnt_o));

  a_r4_runt_step: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (runt_ev && !rx_done_i && runt_cnt_o != MAXV) |=> runt_cnt_o == $past(runt_cnt_o) + 1'b1);

  a_r5_short_ignored: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (runt_end_i && runt_bits_i < MINB && !rx_done_i) |=> $stable(runt_cnt_o));

  a_r6_nomatch_ignored: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (runt_end_i && !runt_match_i && !rx_done_i) |=> $stable(runt_cnt_o));

  a_r7_col_hold_max: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (col_cnt_o == MAXV && !rx_done_i) |=> col_cnt_o == MAXV);

  a_r7_runt_hold_max: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (runt_cnt_o == MAXV && !rx_done_i) |=> runt_cnt_o == MAXV);

  a_r8_clear_col: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (rx_done_i && !col_ev) |=> col_cnt_o == '0);

  a_r8_clear_runt: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (rx_done_i && !runt_ev) |=> runt_cnt_o == '0);

  a_r9_new_interval: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (rx_done_i && col_ev && runt_ev) |=> (col_cnt_o == 1 && runt_cnt_o == 1));

endmodule

bind rxstat_counters rxstat_counters_chk #(
  .CNT_W         (CNT_W),
  .BITS_W        (BITS_W),
  .MIN_RUNT_BITS (MIN_RUNT_BITS)
) u_chk (
  .clk_i        (clk_i),
  .rst_n_sync   (rst_n_sync),
  .col_det_i    (col_det_i),
  .tx_active_i  (tx_active_i),
  .runt_end_i   (runt_end_i),
  .runt_match_i (runt_match_i),
  .runt_bits_i  (runt_bits_i),
  .rx_done_i    (rx_done_i),
  .col_cnt_o    (col_cnt_o),
  .runt_cnt_o   (runt_cnt_o)
);

// File: tb/rxstat_counters_test.sv
module rxstat_counters_test;

  localparam int CNT_W  = 8;
  localparam int BITS_W = 10;
  localparam int MINB   = 48;
  localparam int MAXV   = 255;

  logic              clk;
  logic              rst_n;
  logic              col_det;
  logic              tx_active;
  logic              runt_end;
  logic              runt_match;
  logic [BITS_W-1:0] runt_bits;
  logic              rx_done;
  logic [CNT_W-1:0]  col_cnt;
  logic [CNT_W-1:0]  runt_cnt;

  rxstat_counters #(
    .CNT_W (CNT_W), .BITS_W (BITS_W), .MIN_RUNT_BITS (MINB), .SYNC_STAGES (2)
  ) uut (
    .clk_i (clk), .rst_ni (rst_n), .col_det_i (col_det), .tx_active_i (tx_active),
    .runt_end_i (runt_end), .runt_match_i (runt_match), .runt_bits_i (runt_bits),
    .rx_done_i (rx_done), .col_cnt_o (col_cnt), .runt_cnt_o (runt_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int    col;
    int    runt;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  int    m_col  = 0;
  int    m_runt = 0;
  bit    done_flag = 1'b0;

  task automatic check(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: compares the outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, "col_cnt", int'(col_cnt), e.col);
        check(e.req, "runt_cnt", int'(runt_cnt), e.runt);
      end
    end
  end

  // Driver: one cycle of stimulus, model update, expectation pushed
  task automatic step(input bit c, input bit t, input bit re, input bit rm,
                      input int rb, input bit d, input string req);
    exp_t e;
    bit ci;
    bit ri;
    @(negedge clk);
    col_det = c; tx_active = t; runt_end = re; runt_match = rm;
    runt_bits = BITS_W'(rb); rx_done = d;
    if (d) begin
      // R8: values visible in the strobe cycle belong to this entry
      #1;
      check("R8", "col_cnt at strobe", int'(col_cnt), m_col);
      check("R8", "runt_cnt at strobe", int'(runt_cnt), m_runt);
    end
    @(posedge clk);
    ci = c && !t;
    ri = re && rm && (rb >= MINB);
    if (d) begin
      m_col  = ci ? 1 : 0;
      m_runt = ri ? 1 : 0;
    end else begin
      if (ci && m_col  < MAXV) m_col++;
      if (ri && m_runt < MAXV) m_runt++;
    end
    e.col = m_col; e.runt = m_runt; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    col_det = 0; tx_active = 0; runt_end = 0; runt_match = 0;
    runt_bits = '0; rx_done = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    check("R1", "col_cnt in reset", int'(col_cnt), 0);
    check("R1", "runt_cnt in reset", int'(runt_cnt), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", "col_cnt after reset", int'(col_cnt), 0);
    check("R1", "runt_cnt after reset", int'(runt_cnt), 0);

    step(1, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, "R2");
    idle("R2");
    step(1, 1, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 1, 48, 0, "R4");
    step(0, 0, 1, 1, 200, 0, "R4");
    step(0, 0, 1, 1, 47, 0, "R5");
    step(0, 0, 1, 1, 0, 0, "R5");
    step(0, 0, 1, 0, 60, 0, "R6");
    step(0, 0, 1, 0, 48, 0, "R6");
    step(1, 0, 1, 1, 64, 0, "R10");
    step(1, 1, 1, 1, 64, 0, "R10");
    step(1, 0, 1, 0, 64, 0, "R10");
    step(0, 0, 0, 0, 0, 1, "R8");
    idle("R8");
    step(1, 0, 0, 0, 0, 0, "R9");
    step(1, 0, 1, 1, 50, 1, "R9");
    idle("R9");
    step(1, 1, 1, 1, 47, 1, "R9");
    for (int i = 0; i < 260; i++) step(1, 0, 1, 1, 100, 0, "R7");
    step(1, 0, 1, 1, 100, 0, "R7");
    idle("R7");
    step(0, 0, 0, 0, 0, 1, "R8");
    idle("R8");
    repeat (3) @(negedge clk);
    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule